// File: doc/BRIEF.md
# Page-Mode Parallel ROM Reader

This block is a synchronous read controller for an external asynchronous ROM that offers a fast in-page access. An internal client presents an address, a byte/word mode flag and a request strobe. The controller drives the ROM address bus and the active-low chip enable, output enable and byte-select lines. It waits a fixed number of clock cycles for the ROM output to settle, then samples the data bus and returns the result with a one-cycle valid pulse.

The controller remembers which eight-word page is currently open. A read that changes only the three low word-address bits (and, in byte mode, the byte-select bit) waits only the short page time. A read to a different page, after a mode change, or after the chip has dropped to standby waits the full random time. In byte mode the least significant byte address is driven out on the ROM's top data pin, and the returned value is zero-extended to 16 bits. After a parameterised number of idle cycles the controller releases chip enable, and the ROM goes into standby.

Top module: `prom_page_reader`

## Requirements
- R1: After reset `ready` is 1, `rvalid` is 0, and `rom_ce_n` and `rom_oe_n` are both 1 (standby).
- R2: A request is accepted on a clock edge where `req` and `ready` are both 1. `ready` stays 0 until the result is returned. A `req` seen while `ready` is 0 is ignored and does not change the returned data.
- R3: In word mode (`byte_mode`=0) `rom_addr` equals `addr[AW-1:0]` and `rom_byte_n` is 1. `rdata` is the full 16-bit ROM data bus.
- R4: In byte mode (`byte_mode`=1) `rom_addr` equals `addr[AW:1]`, and `rom_byte_n` is 0. `rom_d15_oe` is 1 and `rom_d15_out` carries `addr[0]` (1 selects the high byte of the word). `rdata` is `{8'h00, rom_dq[7:0]}`.
- R5: A read that is not a page hit has `rvalid` high in the cycle after the Nth rising edge following acceptance. N is the larger of `RAND_CYC` and `OE_CYC`.
- R6: A page hit waits `PAGE_CYC` edges instead. A page hit needs chip enable to be active, the mode to be the same as the previous read, and word-address bits `[AW-1:3]` to equal those of the previous read.
- R7: `rom_addr`, `rom_d15_out` and `rom_byte_n` stay unchanged from acceptance until the data is captured.
- R8: `rvalid` is high for exactly one cycle per accepted request.
- R9: After `IDLE_CYC` consecutive idle cycles with chip enable active, `rom_ce_n` and `rom_oe_n` return to 1. The next read is then treated as random.
- R10: A change of `byte_mode` between reads makes the next read random even when the page bits are the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request strobe |
| byte_mode | input | 1 | 1 = byte read, 0 = word read |
| addr | input | AW+1 | Byte address in byte mode; word address in bits AW-1:0 in word mode |
| ready | output | 1 | Controller idle and able to accept a request |
| rvalid | output | 1 | One-cycle result strobe |
| rdata | output | 16 | Read result, zero-extended in byte mode |
| rom_addr | output | AW | ROM word address |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM byte select, low selects byte mode |
| rom_d15_out | output | 1 | Byte-select address bit driven onto the top data pin |
| rom_d15_oe | output | 1 | Drive enable for the top data pin |
| rom_dq | input | 16 | ROM data bus |

## Verification
The embedded assertions watch, on every cycle, the properties that do not depend on the ROM contents. The ROM address stays stable while a read is in flight. Every result pulse lasts one cycle and arrives no sooner than the page time and no later than the random time. Byte results have a zero upper half. Standby only occurs while the controller is idle. Whether a given read was correctly classed as a page hit or a random access, and whether the data came from the right word and byte, can only be shown by the bench. The bench does this with a timing-aware ROM model that returns garbage unless the ROM's own settle times were met. It runs address sweeps within a page, across pages, across modes and across idle gaps.

// File: rtl/prom_page_reader.sv
module prom_page_reader #(
  parameter int AW       = 21,
  parameter int PB       = 3,
  parameter int RAND_CYC = 7,
  parameter int PAGE_CYC = 3,
  parameter int OE_CYC   = 3,
  parameter int IDLE_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          byte_mode,
  input  logic [AW:0]   addr,
  output logic          ready,
  output logic          rvalid,
  output logic [15:0]   rdata,
  output logic [AW-1:0] rom_addr,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          rom_byte_n,
  output logic          rom_d15_out,
  output logic          rom_d15_oe,
  input  logic [15:0]   rom_dq
);
  localparam int RWAIT = (RAND_CYC > OE_CYC) ? RAND_CYC : OE_CYC;
  localparam int CW    = $clog2(RWAIT + 1);
  localparam int IW    = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] RWAIT_L = CW'(RWAIT);
  localparam logic [CW-1:0] PAGE_L  = CW'(PAGE_CYC);
  localparam logic [IW-1:0] IDLE_L  = IW'(IDLE_CYC - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idle;
  logic          byte_q;
  logic [AW-1:0] waddr_in;
  logic          hit;

  assign waddr_in = byte_mode ? addr[AW:1] : addr[AW-1:0];
  assign hit      = !rom_ce_n && (byte_q == byte_mode) &&
                    (waddr_in[AW-1:PB] == rom_addr[AW-1:PB]);
  assign ready      = !busy;
  assign rom_byte_n = !byte_q;
  assign rom_d15_oe = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      idle        <= '0;
      byte_q      <= 1'b0;
      rom_addr    <= '0;
      rom_d15_out <= 1'b0;
      rom_ce_n    <= 1'b1;
      rom_oe_n    <= 1'b1;
      rvalid      <= 1'b0;
      rdata       <= '0;
    end else begin
      rvalid <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy        <= 1'b1;
          cnt         <= hit ? PAGE_L : RWAIT_L;
          rom_addr    <= waddr_in;
          rom_d15_out <= byte_mode & addr[0];
          byte_q      <= byte_mode;
          rom_ce_n    <= 1'b0;
          rom_oe_n    <= 1'b0;
          idle        <= '0;
        end else if (!rom_ce_n) begin
          if (idle == IDLE_L) begin
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
            idle     <= '0;
          end else begin
            idle <= idle + 1'b1;
          end
        end
      end else if (cnt == CW'(1)) begin
        busy   <= 1'b0;
        rvalid <= 1'b1;
        rdata  <= byte_q ? {8'h00, rom_dq[7:0]} : rom_dq;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  logic [CW:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chk_len <= '0;
    else if (!busy && req) chk_len <= '0;
    else if (busy)        chk_len <= chk_len + 1'b1;
  end

  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(rom_addr) && $stable(rom_d15_out) && $stable(rom_byte_n)));
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  a_r5_wait_window: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (chk_len >= (CW+1)'(PAGE_CYC) && chk_len <= (CW+1)'(RWAIT)));
  a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rom_byte_n) |-> (rdata[15:8] == 8'h00));
  a_r9_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce_n |-> (ready && rom_oe_n));
endmodule

// File: tb/prom_page_reader_tb.sv
module prom_page_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21, RAND = 7, PAGE = 3, OEC = 3, IDLE = 16;
  localparam int RW = (RAND > OEC) ? RAND : OEC;

  logic clk = 0, rst_n = 0, req = 0, byte_mode = 0;
  logic [AW:0] addr = '0;
  logic ready, rvalid, rom_ce_n, rom_oe_n, rom_byte_n, rom_d15_out, rom_d15_oe;
  logic [15:0] rdata, dq;
  logic [AW-1:0] rom_addr;
  int checks = 0, errors = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_page_reader #(.AW(AW), .RAND_CYC(RAND), .PAGE_CYC(PAGE), .OE_CYC(OEC),
    .IDLE_CYC(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .byte_mode(byte_mode), .addr(addr),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .rom_addr(rom_addr),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n),
    .rom_d15_out(rom_d15_out), .rom_d15_oe(rom_d15_oe), .rom_dq(dq));

  function automatic logic [15:0] romw(input logic [AW-1:0] w);
    romw = (w[15:0] * 16'd37) ^ {w[20:16], 11'h5A3};
  endfunction

  logic [AW-1:0] pa = '0;
  logic pa1 = 0, pce = 1, pbyte = 1;
  int rcnt = 0, pcnt = 0;
  always @(negedge clk) begin
    logic [15:0] w;
    if (rom_addr[AW-1:3] != pa[AW-1:3] || rom_ce_n != pce || rom_byte_n != pbyte) rcnt = 1;
    else if (rcnt < 1000) rcnt++;
    if (rom_addr != pa || rom_d15_out != pa1 || rom_ce_n != pce || rom_byte_n != pbyte) pcnt = 1;
    else if (pcnt < 1000) pcnt++;
    pa = rom_addr; pa1 = rom_d15_out; pce = rom_ce_n; pbyte = rom_byte_n;
    w = romw(rom_addr);
    if (rom_ce_n || rom_oe_n || rcnt < RAND || rcnt < OEC || pcnt < PAGE) dq = 16'hBAD5;
    else if (!rom_byte_n) dq = {1'b1, 7'h2A, (rom_d15_oe && rom_d15_out) ? w[15:8] : w[7:0]};
    else dq = w;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic open = 0, omode = 0;
  logic [AW-1:3] opage = '0;

  task automatic do_read(input logic [AW:0] a, input logic bm, input int gap, input bit inject);
    logic [AW-1:0] w = bm ? a[AW:1] : a[AW-1:0];
    logic [15:0] full = romw(w);
    logic [15:0] exp = bm ? {8'h00, a[0] ? full[15:8] : full[7:0]} : full;
    bit hit;
    int expw, cyc = 0;
    bit stable = 1;
    repeat (gap) @(negedge clk);
    if (gap >= IDLE + 2) begin
      check(rom_ce_n && rom_oe_n, "R9 standby after idle", {rom_ce_n, rom_oe_n}, 3);
      open = 0;
    end
    hit = open && omode == bm && opage == w[AW-1:3];
    expw = hit ? PAGE : RW;
    check(ready, "R2 ready before request", ready, 1);
    req = 1; addr = a; byte_mode = bm;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    forever begin
      cyc++;
      if (rvalid) break;
      if (ready || rom_addr != w || rom_byte_n != !bm || (bm && rom_d15_out != a[0])) stable = 0;
      if (inject && cyc == 2) begin req = 1; addr = ~a; byte_mode = ~bm; end
      else begin req = 0; addr = a; byte_mode = bm; end
      @(negedge clk);
    end
    req = 0;
    check(stable, "R7 address held, R2 ready low while busy", stable, 1);
    check(cyc == expw + 1, hit ? "R6 page-hit latency" : "R5 random latency", cyc, expw + 1);
    check(rdata == exp, bm ? "R4 byte data" : "R3 word data", rdata, exp);
    if (bm) check(rom_d15_oe && !rom_byte_n, "R4 byte pins", {rom_d15_oe, rom_byte_n}, 2);
    else    check(rom_byte_n && !rom_d15_oe, "R3 word pins", {rom_d15_oe, rom_byte_n}, 1);
    @(negedge clk);
    check(!rvalid, "R8 single-cycle rvalid", rvalid, 0);
    open = 1; omode = bm; opage = w[AW-1:3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready && !rvalid && rom_ce_n && rom_oe_n, "R1 reset state",
          {ready, rvalid, rom_ce_n, rom_oe_n}, 4'b1011);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) do_read(22'(i), 0, 0, 0);
    for (int i = 7; i >= 0; i--) do_read(22'(16'h1230 + i), 0, (i % 3), 0);
    do_read(22'h000010, 0, 0, 0);
    for (int i = 0; i < 16; i++) do_read(22'h0002A0 + 22'(i), 1, 0, 0);
    do_read(22'h0002A5, 1, 0, 0);
    for (int i = 0; i < 16; i++) do_read(22'h3FFFF0 + 22'(i), 1, 1, 0);
    do_read(22'h3FFFF8, 1, IDLE + 4, 0);
    do_read(22'h3FFFF9, 1, 0, 0);
    // R10: same page, mode switched to word
    do_read(22'h1FFFFC, 0, 0, 0);
    do_read(22'h1FFFFD, 0, 0, 0);
    do_read(22'h1FFFF9, 1, 0, 0);
    do_read(22'h0F0001, 0, 0, 1);
    do_read(22'h0F0002, 0, 0, 1);
    do_read(22'h0F0003, 0, IDLE + 2, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule